// File: doc/BRIEF.md
# Tick-Timed Pin Debounce Filter

This block cleans up one slow input pin before the level reaches an interrupt detector and a pin-status bit. The raw level is first brought into the system clock domain through a flop chain. It then passes through a filter that times stable intervals in units of a slow real-time tick. The tick arrives as a one-cycle enable pulse in the system clock domain. A two-bit unit select picks how many tick pulses form one timing unit. A four-bit count picks how many units a new level must hold before it is accepted.

Four filter modes exist. The off mode forwards the synchronized level on the next cycle. The symmetric mode debounces both edges. The two one-sided modes let one edge through at once and debounce the other. The low-keeping mode suits an active-high level trigger, and the high-keeping mode suits an active-low one. A one-sided mode keeps short pulses toward its fast level and removes short pulses in the other direction. Software clears the filter by writing mode 00 together with zero unit and count. The `rst_n` input is expected to be deasserted in step with `clk`.

Top module: `dbf_filter`

## Requirements
- R1: With `filt_mode` = 00 (off), `pin_filt` equals the level `pin_raw` had three clock edges earlier: two synchronizer stages plus the output register.
- R2: `unit_sel` sets the number of `rtc_tick` pulses per timing unit: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R3: A debounced change is accepted after `tick_count` + 1 whole units, so count 15 means 16 units. In this case `pin_filt` takes the new level on the (`tick_count`+1)×unit-th tick-carrying edge after the synchronized input first differs from it.
- R4: With `filt_mode` = 01 (symmetric), both rising and falling changes are debounced, and `pin_filt` changes only on an edge that completes a timing unit.
- R5: If the synchronized input returns to the current output level before the window expires, the unit and tick counters clear. A later change then has to wait the full window again.
- R6: With `filt_mode` = 10 (keeps low pulses), a falling input reaches `pin_filt` three edges after `pin_raw` changes. A rising input is debounced, so a short high pulse never appears.
- R7: With `filt_mode` = 11 (keeps high pulses), a rising input reaches `pin_filt` three edges after `pin_raw` changes, and a falling input is debounced.
- R8: Timing advances only on cycles with `rtc_tick` high. With no tick pulses a pending change is never accepted, and the window resumes once pulses return.
- R9: While `rst_n` is low, `pin_filt` is 0 and the counters are clear. On the third edge after release, `pin_filt` loads the synchronized raw level in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| rtc_tick | input | 1 | One-cycle enable pulse per real-time clock period |
| filt_mode | input | 2 | 00 off, 01 symmetric, 10 keep low pulses, 11 keep high pulses |
| unit_sel | input | 2 | Tick pulses per unit: 00→2, 01→8, 10→512, 11→2048 |
| tick_count | input | 4 | Units to wait, minus one |
| pin_raw | input | 1 | Asynchronous raw pin level |
| pin_filt | output | 1 | Filtered level |

## Verification
The bound checker watches every cycle. It confirms the three-cycle pass-through in off mode and that the reset load equals the raw level from three edges earlier. It also confirms that a debounced edge in the symmetric or one-sided modes lands only on a completed unit with a tick present, and that the counter is zero whenever nothing is pending. The exact window lengths for each unit code and for the count extremes can only be shown by the bench's scenarios. The same holds for the restart after a short reversal, the stall while ticks are absent, and the immediate pass of the fast edge in the one-sided modes.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    DBF_OFF       = 2'b00,
    DBF_SYMMETRIC = 2'b01,
    DBF_KEEP_LOW  = 2'b10,
    DBF_KEEP_HIGH = 2'b11
  } dbf_mode_e;
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/dbf_prescale.sv
module dbf_prescale #(
  parameter int UNIT_A = 2,
  parameter int UNIT_B = 8,
  parameter int UNIT_C = 512,
  parameter int UNIT_D = 2048,
  parameter int PRE_W  = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rtc_tick,
  input  logic [1:0] unit_sel,
  output logic       unit_tick
);
  logic [PRE_W-1:0] pre_q, pre_d, last_val;
  logic             at_end;

  always_comb begin
    case (unit_sel)
      2'b00:   last_val = PRE_W'(UNIT_A - 1);
      2'b01:   last_val = PRE_W'(UNIT_B - 1);
      2'b10:   last_val = PRE_W'(UNIT_C - 1);
      default: last_val = PRE_W'(UNIT_D - 1);
    endcase
  end

  assign at_end    = (pre_q >= last_val);
  assign unit_tick = run && rtc_tick && at_end;

  always_comb begin
    pre_d = pre_q;
    if (!run)          pre_d = '0;
    else if (rtc_tick) pre_d = at_end ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/dbf_core.sv
module dbf_core
  import dbf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             primed,
  input  logic             lvl_in,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] tmr_limit,
  input  logic             unit_tick,
  output logic             timing,
  output logic [CNT_W-1:0] cnt_out,
  output logic             lvl_out
);
  logic             out_q, out_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             differs, fast_edge;

  assign differs = primed && (lvl_in != out_q);

  always_comb begin
    case (dbf_mode_e'(mode))
      DBF_OFF:       fast_edge = 1'b1;
      DBF_KEEP_LOW:  fast_edge = !lvl_in;
      DBF_KEEP_HIGH: fast_edge = lvl_in;
      default:       fast_edge = 1'b0;
    endcase
  end

  assign timing = differs && !fast_edge;

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (!primed) begin
      out_d = lvl_in;
      cnt_d = '0;
    end else if (!differs) begin
      cnt_d = '0;
    end else if (fast_edge) begin
      out_d = lvl_in;
      cnt_d = '0;
    end else if (unit_tick) begin
      if (cnt_q >= tmr_limit) begin
        out_d = lvl_in;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_out = out_q;
  assign cnt_out = cnt_q;
endmodule

// File: rtl/dbf_filter.sv
module dbf_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int UNIT_A      = 2,
  parameter int UNIT_B      = 8,
  parameter int UNIT_C      = 512,
  parameter int UNIT_D      = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_tick,
  input  logic [1:0]       filt_mode,
  input  logic [1:0]       unit_sel,
  input  logic [CNT_W-1:0] tick_count,
  input  logic             pin_raw,
  output logic             pin_filt
);
  localparam int UMAX_AB    = (UNIT_A > UNIT_B) ? UNIT_A : UNIT_B;
  localparam int UMAX_CD    = (UNIT_C > UNIT_D) ? UNIT_C : UNIT_D;
  localparam int UMAX       = (UMAX_AB > UMAX_CD) ? UMAX_AB : UMAX_CD;
  localparam int PRE_W      = (UMAX > 2) ? $clog2(UMAX) : 1;
  localparam int SETTLE_END = SYNC_STAGES + 1;
  localparam int SET_W      = $clog2(SETTLE_END + 1);

  logic             sync_lvl, unit_tick, timing, primed;
  logic [CNT_W-1:0] tick_cnt;
  logic [SET_W-1:0] settle_q, settle_d;

  assign primed = (settle_q == SET_W'(SETTLE_END));

  always_comb settle_d = primed ? settle_q : settle_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else        settle_q <= settle_d;
  end

  dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_raw),
    .q_out (sync_lvl)
  );

  dbf_prescale #(
    .UNIT_A(UNIT_A), .UNIT_B(UNIT_B), .UNIT_C(UNIT_C), .UNIT_D(UNIT_D), .PRE_W(PRE_W)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (timing),
    .rtc_tick  (rtc_tick),
    .unit_sel  (unit_sel),
    .unit_tick (unit_tick)
  );

  dbf_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .primed    (primed),
    .lvl_in    (sync_lvl),
    .mode      (filt_mode),
    .tmr_limit (tick_count),
    .unit_tick (unit_tick),
    .timing    (timing),
    .cnt_out   (tick_cnt),
    .lvl_out   (pin_filt)
  );
endmodule

// File: rtl/dbf_filter_chk.sv
module dbf_filter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rtc_tick,
  input logic [1:0]       mode,
  input logic             raw,
  input logic             filt,
  input logic             primed,
  input logic             s_q,
  input logic             unit_tick,
  input logic [CNT_W-1:0] tick_cnt
);
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && $past(mode) == 2'b00) |-> filt == $past(raw, 3)); // R1

  AST_SYM_ON_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && $past(mode) == 2'b01 && filt != $past(filt)) |-> $past(unit_tick)); // R4

  AST_ADVANCE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && $past(mode) == 2'b01 && filt != $past(filt)) |-> $past(rtc_tick)); // R8

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && s_q == filt) |=> tick_cnt == '0); // R5

  AST_KEEP_LOW_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && $past(mode) == 2'b10 && $rose(filt)) |-> $past(unit_tick)); // R6

  AST_KEEP_HIGH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && $past(mode) == 2'b11 && $fell(filt)) |-> $past(unit_tick)); // R7

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> filt == $past(raw, 3)); // R9
endmodule

bind dbf_filter dbf_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rtc_tick  (rtc_tick),
  .mode      (filt_mode),
  .raw       (pin_raw),
  .filt      (pin_filt),
  .primed    (primed),
  .s_q       (sync_lvl),
  .unit_tick (unit_tick),
  .tick_cnt  (tick_cnt)
);

// File: tb/test_dbf_filter.sv
module test_dbf_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, rtc_tick, pin_raw, pin_filt;
  logic [1:0] filt_mode, unit_sel;
  logic [3:0] tick_count;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc, n_chk, n_fail;
  bit   done;

  dbf_filter i_dbf_filter (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .filt_mode(filt_mode),
    .unit_sel(unit_sel), .tick_count(tick_count), .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: pin_filt=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  // monitor: pop expectations as their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cyc < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s missed cycle %0d: actual - expected %b", e.tag, e.cyc, e.val);
      end else begin
        check(pin_filt, e.val, e.tag);
      end
    end
  end

  task automatic push(int c, logic v, string tag);
    exp_t e;
    e.cyc = c; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic set_cfg(logic [1:0] m, logic [1:0] u, logic [3:0] t);
    filt_mode = m; unit_sel = u; tick_count = t;
    @(negedge clk);
  endtask

  // change raw level; window of n edges until commit (1 = immediate)
  task automatic drive_change(logic v, int n, string tag);
    int c;
    c = cyc;
    pin_raw = v;
    push(c + 1 + n, !v, tag);
    push(c + 2 + n, v, tag);
    wait_cyc(c + 3 + n);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; rtc_tick = 1'b1; pin_raw = 1'b1;
    filt_mode = 2'b00; unit_sel = 2'b00; tick_count = 4'd0;
    repeat (3) @(negedge clk);
    check(pin_filt, 1'b0, "R9 reset value");
    push(2, 1'b0, "R9 before load");
    push(3, 1'b1, "R9 load raw");
    rst_n = 1'b1;
    wait_cyc(6);

    // R1 off mode pass-through
    drive_change(1'b0, 1, "R1 fall");
    drive_change(1'b1, 1, "R1 rise");

    // R4 symmetric, unit 2, count 2 -> 6 edges
    set_cfg(2'b01, 2'b00, 4'd2);
    drive_change(1'b0, 6, "R4 fall");
    drive_change(1'b1, 6, "R4 rise");

    // R5 short reversal restarts the window
    begin
      int c;
      c = cyc;
      pin_raw = 1'b0;
      wait_cyc(c + 4);
      pin_raw = 1'b1;
      wait_cyc(c + 5);
      pin_raw = 1'b0;
      push(c + 8, 1'b1, "R5 no early commit");
      push(c + 12, 1'b1, "R5 restart old");
      push(c + 13, 1'b0, "R5 restart commit");
      wait_cyc(c + 14);
    end
    drive_change(1'b1, 6, "R5 return");

    // R2 unit codes, R3 count extremes
    set_cfg(2'b01, 2'b01, 4'd0);
    drive_change(1'b0, 8, "R2 unit code 01");
    set_cfg(2'b01, 2'b10, 4'd1);
    drive_change(1'b1, 1024, "R2 unit code 10");
    set_cfg(2'b01, 2'b11, 4'd15);
    drive_change(1'b0, 32768, "R3 code 11 count 15");
    set_cfg(2'b01, 2'b00, 4'd15);
    drive_change(1'b1, 32, "R3 count 15 is 16 units");

    // R6 keep low pulses: fall fast, rise debounced
    set_cfg(2'b10, 2'b00, 4'd1);
    drive_change(1'b0, 1, "R6 fall immediate");
    drive_change(1'b1, 4, "R6 rise debounced");
    drive_change(1'b0, 1, "R6 fall again");
    begin
      int c;
      c = cyc;
      pin_raw = 1'b1;
      wait_cyc(c + 2);
      pin_raw = 1'b0;
      for (int k = 3; k <= 8; k++) push(c + k, 1'b0, "R6 high pulse removed");
      wait_cyc(c + 9);
    end

    // R7 keep high pulses: rise fast, fall debounced
    set_cfg(2'b11, 2'b00, 4'd1);
    drive_change(1'b1, 1, "R7 rise immediate");
    drive_change(1'b0, 4, "R7 fall debounced");

    // R8 no tick pulses -> no progress
    set_cfg(2'b01, 2'b00, 4'd1);
    begin
      int c, d;
      rtc_tick = 1'b0;
      c = cyc;
      pin_raw = 1'b1;
      push(c + 50, 1'b0, "R8 stalled");
      wait_cyc(c + 51);
      d = cyc;
      rtc_tick = 1'b1;
      push(d + 3, 1'b0, "R8 resume old");
      push(d + 4, 1'b1, "R8 resume commit");
      wait_cyc(d + 6);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule